// File: doc/BRIEF.md
# Three-Channel Reload Timer with Watchdog Reset

This block holds three 32-bit down-counters behind a simple register bus. Channel 0 is an event timer that runs either periodically or once. Channel 1 is a free-running timebase: software loads it with all ones and reads elapsed time as all-ones minus the current value. Channel 2 is a watchdog. When it expires and its reset-out gate is open, it drives a sticky reset request.

Each channel counts either the system tick strobe or a fixed-rate tick strobe. Its own select bit picks the source. Both strobes come from outside the block. Each expiry sets a bit in a cause register. A mask register decides which cause bits reach the interrupt outputs. Software clears cause bits by writing zeros to them.

Top module: `tmr_wdg_top`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `wdg_rst_o` is 0.
- R2: The register map is fixed, and every register reads back what was written. Control is at 0x00, with enables in bits 0..2, auto-reload in bits 4..6 and tick select in bits 8..10, bit n belonging to channel n. Cause is at 0x04 (bits 0..2) and mask at 0x08 (bits 0..2). The reset-out enable is 0x0C bit 0. The value of channel n is at 0x10+8n and its reload at 0x14+8n.
- R3: An enabled channel decrements by one on each clock in which its selected tick strobe is high. A disabled channel holds its value.
- R4: A tick-select bit of 0 makes the channel count `sys_tick`. A select bit of 1 makes it count `fast_tick`. The strobe that is not selected has no effect.
- R5: A channel expires when it is enabled and its tick arrives while its value is 0. With auto-reload set, that clock loads the reload value.
- R6: A one-shot channel (auto-reload clear) stays at 0 when it expires, and its enable bit clears in the same clock. No further expiry follows.
- R7: With the reload at 0xFFFFFFFF, a channel wraps from 0 to 0xFFFFFFFF, so all-ones minus the value equals the number of ticks counted.
- R8: A bus write to a value register takes effect at the next clock and overrides a tick in the same clock.
- R9: An expiry sets the channel's cause bit. A write clears the bits written 0 and keeps the bits written 1. An expiry wins over a clear in the same clock.
- R10: `irq[n]` is high exactly when cause bit n and mask bit n are both set.
- R11: An expiry of channel 2 while the reset-out enable is set raises `wdg_rst_o` at that clock edge. It stays high until `rst_n` is asserted.
- R12: With the reset-out enable clear, or with channel 2 disabled, `wdg_rst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| sys_tick | input | 1 | System tick strobe |
| fast_tick | input | 1 | Fixed-rate tick strobe |
| irq | output | 3 | Masked per-channel interrupt requests |
| wdg_rst_o | output | 1 | Sticky watchdog reset request |

## Verification
A counter that steps wrongly shows up on the value read port after a single tick. A wrong expiry decision shows up in the same clock on the cause register. The same fault clears the enable in the control readback too early or too late. A fault in the reset gate appears on `wdg_rst_o` one edge after the expiring tick. A wrong stickiness shows up a few idle cycles later. The sweeps run every start value and reload value over a small range, so every off-by-one near zero and near the reload point changes a readback value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_DW     = 32;
  localparam int TMR_NCH    = 3;
  localparam int TMR_AW     = 6;
  localparam int WDG_CH     = 2;
  // register offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_CAUSE  = 'h04;
  localparam int OFS_MASK   = 'h08;
  localparam int OFS_RSTEN  = 'h0C;
  localparam int OFS_VAL    = 'h10;
  localparam int OFS_RLD    = 'h14;
  localparam int CH_STRIDE  = 8;
  // control field positions
  localparam int EN_LSB     = 0;
  localparam int AUTO_LSB   = 4;
  localparam int SEL_LSB    = 8;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          auto_rl,
  input  logic          tick,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic [DW-1:0] rld,
  output logic [DW-1:0] val,
  output logic          expire
);
  function automatic logic [DW-1:0] step(input logic [DW-1:0] cur,
                                         input logic [DW-1:0] r,
                                         input logic a);
    if (cur == '0) return a ? r : '0;
    return cur - 1'b1;
  endfunction

  logic [DW-1:0] val_q;
  logic          count_w;

  assign count_w = en && tick && !ld;
  assign expire  = count_w && (val_q == '0);
  assign val     = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       val_q <= '0;
    else if (ld)      val_q <= ld_val;
    else if (count_w) val_q <= step(val_q, rld, auto_rl);
  end
endmodule

// File: rtl/tmr_cause.sv
module tmr_cause #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cause_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] expire,
  output logic [N-1:0] cause,
  output logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  logic [N-1:0] cause_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= (cause_wr ? (cause_q & wbits) : cause_q) | expire;
      if (mask_wr) mask_q <= wbits;
    end
  end

  assign cause = cause_q;
  assign mask  = mask_q;
  assign irq   = cause_q & mask_q;
endmodule

// File: rtl/tmr_wdg_rst.sv
module tmr_wdg_rst (
  input  logic clk,
  input  logic rst_n,
  input  logic wdg_expire,
  input  logic gate,
  output logic rst_req
);
  logic req_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   req_q <= 1'b0;
    else if (wdg_expire && gate)  req_q <= 1'b1;
  end
  assign rst_req = req_q;
endmodule

// File: rtl/tmr_wdg_top.sv
module tmr_wdg_top
  import tmr_pkg::*;
#(
  parameter int ADDR_W = TMR_AW,
  parameter int DW     = TMR_DW,
  parameter int NCH    = TMR_NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              sys_tick,
  input  logic              fast_tick,
  output logic [NCH-1:0]    irq,
  output logic              wdg_rst_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_RSTEN = ADDR_W'(OFS_RSTEN);

  logic [NCH-1:0] en_q, auto_q, sel_q;
  logic           rsten_q;
  logic [DW-1:0]  rld_q [NCH];
  logic [DW-1:0]  val_w [NCH];
  logic [NCH-1:0] expire_w, ld_w, rld_wr_w, tick_w;
  logic [NCH-1:0] cause_q, mask_q;
  logic           wr_ctrl_w;
  logic [DW-1:0]  val0_w;

  assign wr_ctrl_w = wr_en && (addr == A_CTRL);
  assign val0_w    = val_w[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ld_w[i]     = wr_en && (addr == ADDR_W'(OFS_VAL + CH_STRIDE * i));
    assign rld_wr_w[i] = wr_en && (addr == ADDR_W'(OFS_RLD + CH_STRIDE * i));
    assign tick_w[i]   = sel_q[i] ? fast_tick : sys_tick;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rld_q[i] <= '0;
      else if (rld_wr_w[i]) rld_q[i] <= wdata;
    end

    tmr_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(en_q[i]), .auto_rl(auto_q[i]),
      .tick(tick_w[i]), .ld(ld_w[i]), .ld_val(wdata), .rld(rld_q[i]),
      .val(val_w[i]), .expire(expire_w[i])
    );
  end

  // control register; bus write wins over the one-shot self-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      auto_q  <= '0;
      sel_q   <= '0;
      rsten_q <= 1'b0;
    end else begin
      if (wr_ctrl_w) begin
        en_q   <= wdata[EN_LSB   +: NCH];
        auto_q <= wdata[AUTO_LSB +: NCH];
        sel_q  <= wdata[SEL_LSB  +: NCH];
      end else begin
        en_q   <= en_q & ~(expire_w & ~auto_q);
      end
      if (wr_en && addr == A_RSTEN) rsten_q <= wdata[0];
    end
  end

  tmr_cause #(.N(NCH)) u_cause (
    .clk(clk), .rst_n(rst_n),
    .cause_wr(wr_en && addr == A_CAUSE), .mask_wr(wr_en && addr == A_MASK),
    .wbits(wdata[NCH-1:0]), .expire(expire_w),
    .cause(cause_q), .mask(mask_q), .irq(irq)
  );

  tmr_wdg_rst u_wdg (
    .clk(clk), .rst_n(rst_n), .wdg_expire(expire_w[WDG_CH]),
    .gate(rsten_q), .rst_req(wdg_rst_o)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[EN_LSB   +: NCH] = en_q;
        rdata[AUTO_LSB +: NCH] = auto_q;
        rdata[SEL_LSB  +: NCH] = sel_q;
      end
      A_CAUSE: rdata[NCH-1:0] = cause_q;
      A_MASK:  rdata[NCH-1:0] = mask_q;
      A_RSTEN: rdata[0]       = rsten_q;
      default: begin
        for (int k = 0; k < NCH; k++) begin
          if (addr == ADDR_W'(OFS_VAL + CH_STRIDE * k)) rdata = val_w[k];
          if (addr == ADDR_W'(OFS_RLD + CH_STRIDE * k)) rdata = rld_q[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/tmr_wdg_chk.sv
module tmr_wdg_chk #(
  parameter int ADDR_W = 6,
  parameter int DW     = 32,
  parameter int NCH    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NCH-1:0]    expire_w,
  input logic [NCH-1:0]    cause_q,
  input logic [NCH-1:0]    en_q,
  input logic [NCH-1:0]    auto_q,
  input logic              rsten_q,
  input logic              wdg_rst_o,
  input logic [DW-1:0]     val0_w
);
  // R9
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire_w) |=> ((cause_q & $past(expire_w)) == $past(expire_w)));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w[0] && !auto_q[0] && !(wr_en && addr == '0)) |=> !en_q[0]);

  // R11
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_o |=> wdg_rst_o);

  // R12
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_rst_o) |-> $past(expire_w[2] && rsten_q));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[0] && !(wr_en && addr == ADDR_W'('h10))) |=> $stable(val0_w));
endmodule

bind tmr_wdg_top tmr_wdg_chk #(.ADDR_W(ADDR_W), .DW(DW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .expire_w(expire_w), .cause_q(cause_q), .en_q(en_q), .auto_q(auto_q),
  .rsten_q(rsten_q), .wdg_rst_o(wdg_rst_o), .val0_w(val0_w)
);

// File: tb/tb_tmr_wdg_top.sv
module tb_tmr_wdg_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CTRL = 6'h00, A_CAUSE = 6'h04, A_MASK = 6'h08,
                         A_RSTEN = 6'h0C;

  logic        clk = 0, rst_n = 0, wr_en = 0, sys_tick = 0, fast_tick = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0]  irq;
  logic        wdg_rst_o;
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_wdg_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sys_tick(sys_tick), .fast_tick(fast_tick),
    .irq(irq), .wdg_rst_o(wdg_rst_o)
  );

  function automatic logic [5:0] a_val(int n); return 6'(16 + 8 * n); endfunction
  function automatic logic [5:0] a_rld(int n); return 6'(20 + 8 * n); endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; sys_tick = 0; fast_tick = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n, input bit fast);
    if (n > 0) begin
      @(negedge clk); if (fast) fast_tick = 1; else sys_tick = 1;
      repeat (n) @(negedge clk);
      sys_tick = 0; fast_tick = 0;
    end
  endtask

  task automatic expect_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d, e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1 reset state
    expect_reg(A_CTRL, 0, "R1 ctrl");
    expect_reg(A_CAUSE, 0, "R1 cause");
    expect_reg(A_MASK, 0, "R1 mask");
    expect_reg(A_RSTEN, 0, "R1 rsten");
    for (int n = 0; n < 3; n++) begin
      expect_reg(a_val(n), 0, "R1 value");
      expect_reg(a_rld(n), 0, "R1 reload");
    end
    chk({31'b0, wdg_rst_o}, 0, "R1 rst");
    chk({29'b0, irq}, 0, "R1 irq");

    // R2 readback
    wr(A_CTRL, 32'h0000_0770); expect_reg(A_CTRL, 32'h0000_0770, "R2 ctrl");
    wr(A_CTRL, 0);
    wr(A_MASK, 32'h5); expect_reg(A_MASK, 32'h5, "R2 mask");
    wr(A_RSTEN, 32'h1); expect_reg(A_RSTEN, 32'h1, "R2 rsten");
    for (int n = 0; n < 3; n++) begin
      wr(a_val(n), 32'hA000_0000 + n); wr(a_rld(n), 32'h0B00_0000 + n);
      expect_reg(a_val(n), 32'hA000_0000 + n, "R2 value");
      expect_reg(a_rld(n), 32'h0B00_0000 + n, "R2 reload");
    end

    // R3 R5 R6 one-shot sweep on channel 0
    for (int v = 0; v < 5; v++) begin
      do_reset();
      wr(a_val(0), v); wr(A_CTRL, 32'h1);
      ticks(v, 0);
      expect_reg(a_val(0), 0, "R3 count down");
      expect_reg(A_CAUSE, 0, "R5 no early expiry");
      expect_reg(A_CTRL, 1, "R6 still enabled");
      ticks(1, 0);
      expect_reg(A_CAUSE, 1, "R5 expiry cause");
      expect_reg(a_val(0), 0, "R6 holds zero");
      expect_reg(A_CTRL, 0, "R6 enable cleared");
      wr(A_CAUSE, 0);
      ticks(3, 0);
      expect_reg(A_CAUSE, 0, "R6 no re-expiry");
    end

    // R5 auto-reload sweep
    for (int v = 0; v < 4; v++)
      for (int r = 1; r < 4; r++) begin
        do_reset();
        wr(a_rld(0), r); wr(a_val(0), v); wr(A_CTRL, 32'h11);
        ticks(v + 1, 0);
        expect_reg(a_val(0), r, "R5 reload");
        expect_reg(A_CAUSE, 1, "R5 cause");
        ticks(r + 1, 0);
        expect_reg(a_val(0), r, "R5 second period");
        expect_reg(A_CTRL, 32'h11, "R5 stays enabled");
      end

    // R4 tick select and R3 disabled hold
    do_reset();
    wr(a_val(1), 10); wr(a_val(2), 5); wr(A_CTRL, 32'h202);
    ticks(4, 0);
    expect_reg(a_val(1), 10, "R4 sys ignored");
    ticks(3, 1);
    expect_reg(a_val(1), 7, "R4 fast counted");
    expect_reg(a_val(2), 5, "R3 disabled holds");
    wr(A_CTRL, 32'h002);
    ticks(2, 1);
    expect_reg(a_val(1), 7, "R4 fast ignored");
    ticks(2, 0);
    expect_reg(a_val(1), 5, "R4 sys counted");

    // R8 write beats tick
    do_reset();
    wr(a_val(0), 9); wr(A_CTRL, 32'h1);
    @(negedge clk); sys_tick = 1; wr_en = 1; addr = a_val(0); wdata = 100;
    @(negedge clk); sys_tick = 0; wr_en = 0;
    expect_reg(a_val(0), 100, "R8 write priority");

    // R7 free-running wrap and elapsed count
    do_reset();
    wr(a_rld(1), 32'hFFFF_FFFF); wr(a_val(1), 2); wr(A_CTRL, 32'h22);
    ticks(3, 0);
    expect_reg(a_val(1), 32'hFFFF_FFFF, "R7 wrap");
    ticks(5, 0);
    rd(a_val(1), d);
    chk(32'hFFFF_FFFF - d, 5, "R7 elapsed");

    // R9 R10 cause clearing and masking
    do_reset();
    wr(a_val(0), 0); wr(A_CTRL, 32'h1);
    ticks(1, 0);
    expect_reg(A_CAUSE, 1, "R9 set");
    chk({29'b0, irq}, 0, "R10 masked");
    wr(A_CAUSE, 32'h7);
    expect_reg(A_CAUSE, 1, "R9 write one keeps");
    wr(A_MASK, 32'h1);
    chk({29'b0, irq}, 1, "R10 unmasked");
    wr(A_CAUSE, 0);
    expect_reg(A_CAUSE, 0, "R9 write zero clears");
    chk({29'b0, irq}, 0, "R10 no cause");
    wr(A_CTRL, 32'h1);
    @(negedge clk); sys_tick = 1; wr_en = 1; addr = A_CAUSE; wdata = 0;
    @(negedge clk); sys_tick = 0; wr_en = 0;
    expect_reg(A_CAUSE, 1, "R9 expiry beats clear");

    // R12 gate closed
    do_reset();
    wr(a_val(2), 1); wr(A_CTRL, 32'h4);
    ticks(2, 0);
    expect_reg(A_CAUSE, 4, "R12 expiry seen");
    chk({31'b0, wdg_rst_o}, 0, "R12 gate closed");
    // R12 channel disabled
    do_reset();
    wr(A_RSTEN, 1); wr(a_val(2), 0);
    ticks(5, 0);
    chk({31'b0, wdg_rst_o}, 0, "R12 channel disabled");
    // R11 reset request
    wr(a_val(2), 1); wr(A_CTRL, 32'h4);
    ticks(1, 0);
    chk({31'b0, wdg_rst_o}, 0, "R11 before expiry");
    ticks(1, 0);
    chk({31'b0, wdg_rst_o}, 1, "R11 asserted");
    wr(A_CTRL, 0); wr(A_RSTEN, 0);
    repeat (4) @(negedge clk);
    chk({31'b0, wdg_rst_o}, 1, "R11 sticky");
    do_reset();
    chk({31'b0, wdg_rst_o}, 0, "R11 cleared by reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule